// File: doc/BRIEF.md
# Machine Cycle State Controller

This controller steps an 8-bit processor through its machine cycles. A normal instruction uses two cycles: a fetch cycle that reads the opcode, then an execute cycle. Service cycles for direct memory access (DMA) and interrupts are whole machine cycles. The controller inserts them only at cycle boundaries that follow an execute, idle, DMA or interrupt cycle, and never right after a fetch. A register datapath outside this block follows the strobes the controller produces. The strobes tell it to save the X and P designators into T and force new values (interrupt entry), or to advance the DMA pointer register R(0) once a DMA transfer has finished.

The datapath supplies a cycle-boundary strobe `cyc_end`. The controller makes every decision on a clock where that strobe is high, and its registered outputs take their new values on that same edge. The fetched instruction's two nibbles must be valid on the boundary that ends the fetch cycle. Opcode 00 puts the controller into a repeating idle cycle. Reset does the same, and the datapath clears P, R(0) and sets interrupt enable from the same reset. Idle ends only through a DMA request, or through an interrupt request while interrupts are enabled. When the active-low load input is held low, the controller services DMA cycles only and otherwise stays idle. This mode is used to fill memory before any program runs.

Top module: `mcs_top`

## Requirements
- R1: While `rst` is high, and after it falls until the first boundary: `cyc_o`=1, `sc_o`=3'b111, `idle_o`=1, and `dma_wr_o`, `save_t_o`, `force_xp_o`, `inc_r0_o` are all 0.
- R2: When `cyc_end` is low on a clock edge, `cyc_o`, `sc_o`, `idle_o` and `dma_wr_o` hold their values, and `save_t_o`, `force_xp_o`, `inc_r0_o` are 0 after that edge.
- R3: `sc_o` is {SC2,SC1,SC0}. Fetch gives 011. Execute gives 110 when the opcode high nibble fetched on the preceding boundary equals 6, and 111 otherwise. Idle gives 111. DMA gives 101. Interrupt gives 100. `cyc_o` encodes fetch=0, execute and idle=1, DMA=2, interrupt=3.
- R4: At the boundary that ends a fetch, the next cycle is an execute cycle, or idle when the opcode (`op_hi`,`op_lo`) is 0x00. Requests are not serviced at this boundary.
- R5: At any other boundary, a DMA request (`dma_in_req` or `dma_out_req`) starts a DMA cycle ahead of any interrupt. During that DMA cycle `dma_wr_o` is 1 if `dma_in_req` was high, and 0 if only `dma_out_req` was high.
- R6: An interrupt cycle starts at such a boundary only when `intr_req`, `ie` and `load_n` are all 1 and no DMA is requested. `save_t_o` and `force_xp_o` are then high together for exactly the first clock of that cycle.
- R7: `inc_r0_o` is high for exactly one clock, the first clock after each DMA cycle ends.
- R8: At a boundary with no request serviced, a cycle that was execute, DMA or interrupt is followed by fetch. Idle is followed by idle. A DMA cycle that ended idle is therefore followed by fetch.
- R9: In idle with no request, the controller stays idle indefinitely with `idle_o`=1 and code 111.
- R10: While `load_n` is 0, every boundary that does not end a fetch leads to a DMA cycle or to idle, never to fetch or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (clear) |
| cyc_end | input | 1 | High on the last clock of each machine cycle |
| load_n | input | 1 | Active-low load mode |
| dma_in_req | input | 1 | DMA request, device to memory |
| dma_out_req | input | 1 | DMA request, memory to device |
| intr_req | input | 1 | Interrupt request |
| ie | input | 1 | Interrupt enable bit from the datapath |
| op_hi | input | 4 | Fetched opcode high nibble |
| op_lo | input | 4 | Fetched opcode low nibble |
| cyc_o | output | 2 | Current cycle type |
| sc_o | output | 3 | State code {SC2,SC1,SC0} |
| idle_o | output | 1 | Idle loop active |
| dma_wr_o | output | 1 | DMA cycle writes memory |
| save_t_o | output | 1 | Copy X,P into T |
| force_xp_o | output | 1 | Set X=2, P=1 |
| inc_r0_o | output | 1 | Increment R(0) |

## Verification
Two functions collide at one boundary: a DMA request and an enabled interrupt request arrive together, or a DMA cycle ends while the next service decision is made. The bench raises both DMA and interrupt requests across the same boundary. It expects a DMA cycle first, then the interrupt cycle at the next boundary. It also holds DMA requests across two boundaries, so a second DMA cycle begins in the same clock that `inc_r0_o` reports the first one finished. A behavioural model in the bench predicts every output on every clock.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef enum logic [2:0] {
    ST_FETCH = 3'd0,
    ST_EXEC  = 3'd1,
    ST_IDLE  = 3'd2,
    ST_DMA   = 3'd3,
    ST_INTR  = 3'd4
  } mcs_st_e;

  localparam int CYC_W = 2;
  localparam int SC_W  = 3;

  localparam logic [CYC_W-1:0] CYC_FETCH = 2'd0;
  localparam logic [CYC_W-1:0] CYC_EXEC  = 2'd1;
  localparam logic [CYC_W-1:0] CYC_DMA   = 2'd2;
  localparam logic [CYC_W-1:0] CYC_INTR  = 2'd3;

  localparam logic [SC_W-1:0] SC_FETCH   = 3'b011;
  localparam logic [SC_W-1:0] SC_EXEC    = 3'b111;
  localparam logic [SC_W-1:0] SC_EXEC_IO = 3'b110;
  localparam logic [SC_W-1:0] SC_DMA     = 3'b101;
  localparam logic [SC_W-1:0] SC_INTR    = 3'b100;
endpackage

// File: rtl/mcs_arbiter.sv
module mcs_arbiter
  import mcs_pkg::*;
#(
  parameter int NIB_W        = 4,
  parameter int IO_HI        = 6,
  parameter int HALT_OP      = 0,
  parameter bit DMA_IN_FIRST = 1'b1
) (
  input  mcs_st_e            cur_st,
  input  logic               load_n,
  input  logic               dma_in_req,
  input  logic               dma_out_req,
  input  logic               intr_req,
  input  logic               ie,
  input  logic [NIB_W-1:0]   op_hi,
  input  logic [NIB_W-1:0]   op_lo,
  output mcs_st_e            nxt_st,
  output logic               nxt_io,
  output logic               nxt_wr
);
  localparam int OP_W = 2 * NIB_W;
  localparam logic [OP_W-1:0]  HALT_CODE = OP_W'(HALT_OP);
  localparam logic [NIB_W-1:0] IO_CODE   = NIB_W'(IO_HI);

  logic dma_any;
  logic dir_in;
  assign dma_any = dma_in_req | dma_out_req;

  generate
    if (DMA_IN_FIRST) begin : g_in_first
      assign dir_in = dma_in_req;
    end else begin : g_out_first
      assign dir_in = ~dma_out_req;
    end
  endgenerate

  always_comb begin
    nxt_st = ST_FETCH;
    nxt_io = 1'b0;
    nxt_wr = 1'b0;
    if (cur_st == ST_FETCH) begin
      nxt_io = (op_hi == IO_CODE);
      nxt_st = ({op_hi, op_lo} == HALT_CODE) ? ST_IDLE : ST_EXEC;
      if ({op_hi, op_lo} == HALT_CODE) nxt_io = 1'b0;
    end else if (dma_any) begin
      nxt_st = ST_DMA;
      nxt_wr = dir_in;
    end else if (intr_req && ie && load_n) begin
      nxt_st = ST_INTR;
    end else if (!load_n || cur_st == ST_IDLE) begin
      nxt_st = ST_IDLE;
    end else begin
      nxt_st = ST_FETCH;
    end
  end
endmodule

// File: rtl/mcs_code_gen.sv
module mcs_code_gen
  import mcs_pkg::*;
(
  input  mcs_st_e         st,
  input  logic            io,
  output logic [CYC_W-1:0] cyc,
  output logic [SC_W-1:0]  sc
);
  always_comb begin
    unique case (st)
      ST_FETCH: begin cyc = CYC_FETCH; sc = SC_FETCH; end
      ST_EXEC:  begin cyc = CYC_EXEC;  sc = io ? SC_EXEC_IO : SC_EXEC; end
      ST_IDLE:  begin cyc = CYC_EXEC;  sc = SC_EXEC; end
      ST_DMA:   begin cyc = CYC_DMA;   sc = SC_DMA; end
      ST_INTR:  begin cyc = CYC_INTR;  sc = SC_INTR; end
      default:  begin cyc = CYC_EXEC;  sc = SC_EXEC; end
    endcase
  end
endmodule

// File: rtl/mcs_top.sv
module mcs_top
  import mcs_pkg::*;
#(
  parameter int NIB_W        = 4,
  parameter int IO_HI        = 6,
  parameter int HALT_OP      = 0,
  parameter bit DMA_IN_FIRST = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_end,
  input  logic             load_n,
  input  logic             dma_in_req,
  input  logic             dma_out_req,
  input  logic             intr_req,
  input  logic             ie,
  input  logic [NIB_W-1:0] op_hi,
  input  logic [NIB_W-1:0] op_lo,
  output logic [1:0]       cyc_o,
  output logic [2:0]       sc_o,
  output logic             idle_o,
  output logic             dma_wr_o,
  output logic             save_t_o,
  output logic             force_xp_o,
  output logic             inc_r0_o
);
  mcs_st_e          st_q;
  mcs_st_e          nxt_st;
  logic             nxt_io;
  logic             nxt_wr;
  logic [CYC_W-1:0] nxt_cyc;
  logic [SC_W-1:0]  nxt_sc;

  mcs_arbiter #(
    .NIB_W(NIB_W), .IO_HI(IO_HI), .HALT_OP(HALT_OP), .DMA_IN_FIRST(DMA_IN_FIRST)
  ) arb_i (
    .cur_st(st_q), .load_n(load_n), .dma_in_req(dma_in_req),
    .dma_out_req(dma_out_req), .intr_req(intr_req), .ie(ie),
    .op_hi(op_hi), .op_lo(op_lo),
    .nxt_st(nxt_st), .nxt_io(nxt_io), .nxt_wr(nxt_wr)
  );

  mcs_code_gen code_i (
    .st(nxt_st), .io(nxt_io), .cyc(nxt_cyc), .sc(nxt_sc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      cyc_o      <= CYC_EXEC;
      sc_o       <= SC_EXEC;
      idle_o     <= 1'b1;
      dma_wr_o   <= 1'b0;
      save_t_o   <= 1'b0;
      force_xp_o <= 1'b0;
      inc_r0_o   <= 1'b0;
    end else if (cyc_end) begin
      st_q       <= nxt_st;
      cyc_o      <= nxt_cyc;
      sc_o       <= nxt_sc;
      idle_o     <= (nxt_st == ST_IDLE);
      dma_wr_o   <= (nxt_st == ST_DMA) && nxt_wr;
      save_t_o   <= (nxt_st == ST_INTR);
      force_xp_o <= (nxt_st == ST_INTR);
      inc_r0_o   <= (st_q == ST_DMA);
    end else begin
      save_t_o   <= 1'b0;
      force_xp_o <= 1'b0;
      inc_r0_o   <= 1'b0;
    end
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cyc_end |=> $stable(cyc_o) && $stable(sc_o) && !save_t_o && !inc_r0_o);

  // R4
  fetch_then_exec_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_end && cyc_o == CYC_FETCH |=> cyc_o == CYC_EXEC);

  // R5
  dma_first_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_end && cyc_o != CYC_FETCH && (dma_in_req || dma_out_req) |=> cyc_o == CYC_DMA);

  // R6
  intr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_end && !(ie && load_n) |=> cyc_o != CYC_INTR);

  // R6
  save_pair_chk: assert property (@(posedge clk) disable iff (rst)
    save_t_o |-> force_xp_o && cyc_o == CYC_INTR);

  // R7
  inc_after_dma_chk: assert property (@(posedge clk) disable iff (rst)
    inc_r0_o |-> $past(cyc_o) == CYC_DMA);

  // R10
  load_no_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_end && !load_n && cyc_o != CYC_FETCH |=> cyc_o != CYC_FETCH);
endmodule

// File: tb/mcs_top_tb_top.sv
`timescale 1ns/1ps
module mcs_top_tb_top;
  logic clk = 0;
  logic rst = 1;
  logic cyc_end = 0;
  logic load_n = 1, dma_in_req = 0, dma_out_req = 0, intr_req = 0, ie = 0;
  logic [3:0] op_hi = 4'h1, op_lo = 4'h2;
  logic [1:0] cyc_o;
  logic [2:0] sc_o;
  logic idle_o, dma_wr_o, save_t_o, force_xp_o, inc_r0_o;

  int n_chk = 0, n_fail = 0;
  int per = 4, cnt = 0;
  bit done = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  mcs_top dut_i (
    .clk(clk), .rst(rst), .cyc_end(cyc_end), .load_n(load_n),
    .dma_in_req(dma_in_req), .dma_out_req(dma_out_req), .intr_req(intr_req),
    .ie(ie), .op_hi(op_hi), .op_lo(op_lo), .cyc_o(cyc_o), .sc_o(sc_o),
    .idle_o(idle_o), .dma_wr_o(dma_wr_o), .save_t_o(save_t_o),
    .force_xp_o(force_xp_o), .inc_r0_o(inc_r0_o)
  );

  // model: 0 fetch, 1 exec, 2 idle, 3 dma, 4 intr
  int m_st = 2;
  bit m_io = 0, m_wr = 0, m_save = 0, m_inc = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 2; m_io = 0; m_wr = 0; m_save = 0; m_inc = 0;
    end else if (cyc_end) begin
      int prev;
      prev = m_st; m_io = 0; m_wr = 0;
      if (prev == 0) begin
        if (op_hi == 0 && op_lo == 0) m_st = 2;
        else begin m_st = 1; m_io = (op_hi == 4'h6); end
      end else if (dma_in_req || dma_out_req) begin
        m_st = 3; m_wr = dma_in_req;
      end else if (intr_req && ie && load_n) m_st = 4;
      else if (!load_n || prev == 2) m_st = 2;
      else m_st = 0;
      m_save = (m_st == 4);
      m_inc = (prev == 3);
    end else begin
      m_save = 0; m_inc = 0;
    end
  end

  task automatic chk(input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int exp_sc();
    case (m_st)
      0: return 3;
      1: return m_io ? 6 : 7;
      3: return 5;
      4: return 4;
      default: return 7;
    endcase
  endfunction

  function automatic int exp_cyc();
    case (m_st)
      0: return 0;
      3: return 2;
      4: return 3;
      default: return 1;
    endcase
  endfunction

  // cycle boundary strobe generator
  always @(negedge clk) begin
    if (per == 0) cyc_end <= 0;
    else begin
      cnt = cnt + 1;
      cyc_end <= (cnt % per == 0);
    end
  end

  // compare every clock
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cyc_o, exp_cyc(), "cyc_o");
      chk(sc_o, exp_sc(), "sc_o (R3)");
      chk(idle_o, m_st == 2, "idle_o");
      chk(dma_wr_o, m_st == 3 && m_wr, "dma_wr_o");
      chk(save_t_o, m_save, "save_t_o");
      chk(force_xp_o, m_save, "force_xp_o");
      chk(inc_r0_o, m_inc, "inc_r0_o (R7)");
    end
  end

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    clks(3);
    tag = "R1";
    chk(cyc_o, 1, "reset cyc_o R1");
    chk(sc_o, 7, "reset sc_o R1");
    chk(idle_o, 1, "reset idle_o R1");
    chk({dma_wr_o, save_t_o, force_xp_o, inc_r0_o}, 0, "reset strobes R1");
    rst = 0;
    clks(2);
    chk(sc_o, 7, "post reset sc_o R1");
    tag = "R9"; clks(20);
    tag = "R8";
    dma_out_req = 1; clks(4); dma_out_req = 0;
    op_hi = 4'h6; op_lo = 4'h1;
    tag = "R3"; clks(8);
    op_hi = 4'h1; op_lo = 4'h2; clks(8);
    tag = "R6";
    ie = 1; intr_req = 1; clks(4); intr_req = 0; ie = 0; clks(12);
    intr_req = 1; clks(16); intr_req = 0;
    tag = "R5";
    ie = 1; intr_req = 1; dma_in_req = 1; clks(4); dma_in_req = 0; clks(4);
    intr_req = 0; ie = 0; clks(8);
    dma_in_req = 1; dma_out_req = 1; clks(4); dma_in_req = 0; dma_out_req = 0; clks(8);
    tag = "R4";
    op_hi = 4'h0; op_lo = 4'h0; clks(12); op_hi = 4'h1; clks(12);
    tag = "R7";
    dma_in_req = 1; clks(8); dma_in_req = 0; clks(12);
    tag = "R10";
    load_n = 0; clks(8); dma_out_req = 1; clks(8); dma_out_req = 0;
    ie = 1; intr_req = 1; clks(8); intr_req = 0; ie = 0; clks(8);
    load_n = 1; clks(8); dma_in_req = 1; clks(4); dma_in_req = 0; clks(12);
    tag = "R2";
    per = 0; clks(3); dma_in_req = 1; ie = 1; intr_req = 1; clks(20);
    dma_in_req = 0; per = 3; clks(12);
    intr_req = 0; ie = 0; per = 7; clks(35);
    per = 1; op_hi = 4'h6; clks(10);
    finish_run();
  end
endmodule